// File: doc/BRIEF.md
# Quarter-Turn Sliding DFT Element for a 4×4 Window

This block tracks one bin of a two-dimensional discrete Fourier transform over a window of sixteen complex samples: four columns of four rows each. Samples arrive one per valid cycle in column order, with the row index running fastest. Each valid sample updates a complex state register in a single cycle. For a 4×4 window every rotation factor has components that are only 0, +1 or −1. The update therefore needs only sign changes, real/imaginary swaps and four adders, and no multiplier.

The state update needs a difference between the incoming sample and the sample that leaves the window. A sixteen-entry delay line holds the recent samples and supplies the leaving one. A small controller does three things. It tracks the row position. It picks the rotation applied to the state: the column angle on an ordinary step, and the combined angle on the first row of a column. It raises a one-cycle strobe after each column completes. Two 2-bit inputs select the bin. They are taken on the first clock edge after reset and then frozen.

Top module: `sdft4_elem`

## Requirements
- R1: While reset is active and on the first cycle after it is released, `y_re_o`, `y_im_o` and `strobe_o` are all zero.
- R2: The bin indices `k1_i` and `k2_i` are captured on the first rising clock edge after reset release, and that edge's update already uses them. Later changes of `k1_i` or `k2_i` have no effect on the outputs.
- R3: On a cycle with `valid_i` low, the state outputs keep their value and `strobe_o` is low on the following cycle.
- R4: Each valid sample forms a difference d = x − x_old. Here x_old is the sample accepted exactly sixteen valid samples earlier, or zero if fewer than sixteen samples have been accepted since reset.
- R5: On a valid sample in rows 1 to 3 of a column, the new state is rot(y, k1) + rot(d, k1+k2).
- R6: On a valid sample in row 0 of a column (the column-wrap step, including the first sample after reset), the new state is rot(y, k1+k2) + rot(d, k1+k2).
- R7: rot(v, q) turns v by (q mod 4) quarter turns counter-clockwise. Quarter turn 0 gives (re, im), 1 gives (−im, re), 2 gives (−re, −im) and 3 gives (im, −re).
- R8: `strobe_o` is high for exactly one cycle, the cycle after the valid sample in row 3 of a column (the 4th, 8th, 12th, … valid sample since reset), and low otherwise.
- R9: Each state component stays within ±16·2^(DW−1) for any input stream, including full-scale negative inputs, so the state never wraps.
- R10: The state produced by a valid sample appears on `y_re_o`/`y_im_o` on the cycle after the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| k1_i | input | 2 | Column-direction bin index |
| k2_i | input | 2 | Row-direction bin index |
| valid_i | input | 1 | Sample present on `re_i`/`im_i` |
| re_i | input | DW | Sample real part, signed |
| im_i | input | DW | Sample imaginary part, signed |
| y_re_o | output | DW+GUARD | State real part, signed |
| y_im_o | output | DW+GUARD | State imaginary part, signed |
| strobe_o | output | 1 | Column complete, one cycle |

## Verification
The state is a running recursion, so any wrong internal value stays in `y_re_o`/`y_im_o` from the cycle after the faulty update. It is removed only when the delay line flushes the contribution sixteen samples later, and not even then if the rotation was wrong. The following are all visible at the ports within a few cycles: a rotation picked for the wrong row, a delay tap one place off, or a row counter out of step. The stimulus mixes random data, full-scale negative data, an isolated impulse and gaps in `valid_i` across all sixteen bins, so that each of these errors shows. A slipped row counter also shifts `strobe_o` by at least one valid sample.

// File: rtl/sdft4_pkg.sv
package sdft4_pkg;
  localparam int unsigned N1    = 4;
  localparam int unsigned N2    = 4;
  localparam int unsigned DEPTH = N1 * N2;
  localparam int unsigned QW    = 2;

  typedef logic [QW-1:0] quarter_t;
endpackage

// File: rtl/sdft4_delay.sv
module sdft4_delay #(
  parameter int unsigned DW    = 12,
  parameter int unsigned DEPTH = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 shift_i,
  input  logic signed [DW-1:0] re_i,
  input  logic signed [DW-1:0] im_i,
  output logic signed [DW-1:0] old_re_o,
  output logic signed [DW-1:0] old_im_o
);
  logic signed [DW-1:0] re_q [DEPTH];
  logic signed [DW-1:0] im_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        re_q[i] <= '0;
        im_q[i] <= '0;
      end
    end else if (shift_i) begin
      re_q[0] <= re_i;
      im_q[0] <= im_i;
      for (int i = 1; i < DEPTH; i++) begin
        re_q[i] <= re_q[i-1];
        im_q[i] <= im_q[i-1];
      end
    end
  end

  // entry leaving the window on this shift
  assign old_re_o = re_q[DEPTH-1];
  assign old_im_o = im_q[DEPTH-1];
endmodule

// File: rtl/sdft4_rot.sv
module sdft4_rot
  import sdft4_pkg::*;
#(
  parameter int unsigned W = 17
) (
  input  quarter_t            q_i,
  input  logic signed [W-1:0] re_i,
  input  logic signed [W-1:0] im_i,
  output logic signed [W-1:0] re_o,
  output logic signed [W-1:0] im_o
);
  always_comb begin
    unique case (q_i)
      2'd0: begin re_o = re_i;  im_o = im_i;  end
      2'd1: begin re_o = -im_i; im_o = re_i;  end
      2'd2: begin re_o = -re_i; im_o = -im_i; end
      default: begin re_o = im_i; im_o = -re_i; end
    endcase
  end
endmodule

// File: rtl/sdft4_ctrl.sv
module sdft4_ctrl
  import sdft4_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     valid_i,
  input  quarter_t k1_i,
  input  quarter_t k2_i,
  output quarter_t q_state_o,
  output quarter_t q_diff_o,
  output logic     strobe_o
);
  localparam int unsigned RW = $clog2(N1);

  logic          cfg_done_q;
  quarter_t      k1_q, ksum_q, k1_eff, ksum_eff;
  logic [RW-1:0] row_q;
  logic          wrap, last;

  // first edge after reset uses the live pins, later edges the captured copy
  assign k1_eff   = cfg_done_q ? k1_q   : k1_i;
  assign ksum_eff = cfg_done_q ? ksum_q : quarter_t'(k1_i + k2_i);

  assign wrap = (row_q == '0);
  assign last = (row_q == RW'(N1-1));

  assign q_state_o = wrap ? ksum_eff : k1_eff;
  assign q_diff_o  = ksum_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_done_q <= 1'b0;
      k1_q       <= '0;
      ksum_q     <= '0;
      row_q      <= '0;
      strobe_o   <= 1'b0;
    end else begin
      if (!cfg_done_q) begin
        cfg_done_q <= 1'b1;
        k1_q       <= k1_i;
        ksum_q     <= quarter_t'(k1_i + k2_i);
      end
      strobe_o <= valid_i && last;
      if (valid_i) row_q <= last ? '0 : row_q + 1'b1;
    end
  end
endmodule

// File: rtl/sdft4_elem.sv
module sdft4_elem
  import sdft4_pkg::*;
#(
  parameter int unsigned DW    = 12,
  parameter int unsigned GUARD = 5
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [1:0]                 k1_i,
  input  logic [1:0]                 k2_i,
  input  logic                       valid_i,
  input  logic signed [DW-1:0]       re_i,
  input  logic signed [DW-1:0]       im_i,
  output logic signed [DW+GUARD-1:0] y_re_o,
  output logic signed [DW+GUARD-1:0] y_im_o,
  output logic                       strobe_o
);
  localparam int unsigned SW = DW + GUARD;

  quarter_t             q_state, q_diff;
  logic signed [DW-1:0] old_re, old_im;
  logic signed [SW-1:0] d_re, d_im, ry_re, ry_im, rd_re, rd_im;
  logic signed [SW-1:0] y_re_q, y_im_q;

  sdft4_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .k1_i     (k1_i),
    .k2_i     (k2_i),
    .q_state_o(q_state),
    .q_diff_o (q_diff),
    .strobe_o (strobe_o)
  );

  sdft4_delay #(.DW(DW), .DEPTH(DEPTH)) u_dly (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (valid_i),
    .re_i    (re_i),
    .im_i    (im_i),
    .old_re_o(old_re),
    .old_im_o(old_im)
  );

  // adders 1 and 2: new minus leaving sample
  assign d_re = SW'(re_i) - SW'(old_re);
  assign d_im = SW'(im_i) - SW'(old_im);

  sdft4_rot #(.W(SW)) u_rot_y (
    .q_i (q_state),
    .re_i(y_re_q),
    .im_i(y_im_q),
    .re_o(ry_re),
    .im_o(ry_im)
  );

  sdft4_rot #(.W(SW)) u_rot_d (
    .q_i (q_diff),
    .re_i(d_re),
    .im_i(d_im),
    .re_o(rd_re),
    .im_o(rd_im)
  );

  // adders 3 and 4: state accumulate
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_re_q <= '0;
      y_im_q <= '0;
    end else if (valid_i) begin
      y_re_q <= ry_re + rd_re;
      y_im_q <= ry_im + rd_im;
    end
  end

  assign y_re_o = y_re_q;
  assign y_im_o = y_im_q;
endmodule

// File: rtl/sdft4_elem_chk.sv
module sdft4_elem_chk
  import sdft4_pkg::*;
#(
  parameter int unsigned DW    = 12,
  parameter int unsigned GUARD = 5
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       valid_i,
  input logic                       strobe_o,
  input logic signed [DW+GUARD-1:0] y_re_o,
  input logic signed [DW+GUARD-1:0] y_im_o,
  input quarter_t                   q_diff
);
  localparam longint LIM = longint'(1) << (DW + 3);

  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(y_re_o) && $stable(y_im_o) && !strobe_o);

  p_strobe_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> $past(valid_i));

  p_strobe_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);

  p_bin_frozen_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> $stable(q_diff));

  p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (longint'(y_re_o) <= LIM) && (longint'(y_re_o) >= -LIM) &&
    (longint'(y_im_o) <= LIM) && (longint'(y_im_o) >= -LIM));
endmodule

bind sdft4_elem sdft4_elem_chk #(.DW(DW), .GUARD(GUARD)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .strobe_o(strobe_o),
  .y_re_o  (y_re_o),
  .y_im_o  (y_im_o),
  .q_diff  (q_diff)
);

// File: tb/test_sdft4_elem.sv
`timescale 1ns/1ps
module test_sdft4_elem;
  localparam int DW = 12;
  localparam int GUARD = 5;
  localparam int SW = DW + GUARD;
  localparam int STEPS = 72;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [1:0]           k1 = '0, k2 = '0;
  logic                 valid = 1'b0;
  logic signed [DW-1:0] x_re = '0, x_im = '0;
  logic signed [SW-1:0] y_re, y_im;
  logic                 strobe;

  int vectors = 0, fails = 0;
  bit done = 0;

  // reference state
  int m_re, m_im, m_row, m_k1, m_ks;
  bit m_strobe;
  string m_tag;
  int h_re[$], h_im[$];

  always #2.5 clk = ~clk;

  sdft4_elem #(.DW(DW), .GUARD(GUARD)) i_sdft4_elem (
    .clk_i(clk), .rst_ni(rst_n), .k1_i(k1), .k2_i(k2), .valid_i(valid),
    .re_i(x_re), .im_i(x_im), .y_re_o(y_re), .y_im_o(y_im), .strobe_o(strobe)
  );

  // R7: quarter-turn rotation as multiplication by cos/sin of q*90 degrees
  function automatic int cq(int q);
    case (q % 4) 0: return 1; 1: return 0; 2: return -1; default: return 0; endcase
  endfunction
  function automatic int sq(int q);
    case (q % 4) 0: return 0; 1: return 1; 2: return 0; default: return -1; endcase
  endfunction

  task automatic model_reset();
    m_re = 0; m_im = 0; m_row = 0; m_strobe = 0; m_tag = "R1";
    h_re.delete(); h_im.delete();
    for (int i = 0; i < 16; i++) begin h_re.push_back(0); h_im.push_back(0); end
  endtask

  task automatic model_step(bit v, int xr, int xi);
    int dr, di, qs, ar, ai, br, bi;
    m_strobe = 0;
    if (!v) begin m_tag = "R3"; return; end
    // R4: difference against the sample sixteen accepted samples back
    dr = xr - h_re.pop_front(); di = xi - h_im.pop_front();
    h_re.push_back(xr); h_im.push_back(xi);
    qs = (m_row == 0) ? m_ks : m_k1;   // R6 wrap vs R5 ordinary
    m_tag = (m_row == 0) ? "R6" : "R5";
    ar = m_re * cq(qs) - m_im * sq(qs); ai = m_re * sq(qs) + m_im * cq(qs);
    br = dr * cq(m_ks) - di * sq(m_ks); bi = dr * sq(m_ks) + di * cq(m_ks);
    m_re = ar + br; m_im = ai + bi;
    m_strobe = (m_row == 3);           // R8
    m_row = (m_row + 1) % 4;
  endtask

  // R10: model updated with the driven inputs is compared one cycle later
  task automatic compare();
    vectors++;
    if (int'(y_re) != m_re || int'(y_im) != m_im) begin
      fails++;
      $display("FAIL %s state: got (%0d,%0d) exp (%0d,%0d)", m_tag, y_re, y_im, m_re, m_im);
    end else if (strobe != m_strobe) begin
      fails++;
      $display("FAIL R8 strobe: got %0b exp %0b", strobe, m_strobe);
    end
  endtask

  task automatic run(int kk1, int kk2, int mode);
    int lim;
    lim = 1 << (DW - 1);
    @(negedge clk);
    rst_n = 1'b0; valid = 1'b0; x_re = '0; x_im = '0;
    k1 = 2'(kk1); k2 = 2'(kk2);
    m_k1 = kk1; m_ks = (kk1 + kk2) % 4;
    model_reset();
    repeat (2) @(negedge clk);
    compare();                          // R1 during reset
    rst_n = 1'b1;
    for (int s = 0; s < STEPS; s++) begin
      bit v;
      int xr, xi;
      compare();
      if (s > 0) begin k1 = 2'($urandom); k2 = 2'($urandom); end  // R2: ignored
      v = (mode == 2) ? 1'b1 : (($urandom % 5) != 0);
      case (mode)
        0: begin xr = int'($urandom % (2 * lim)) - lim; xi = int'($urandom % (2 * lim)) - lim; end
        1: begin xr = -lim; xi = -lim; end       // R9 full-scale negative
        default: begin xr = (s == 1) ? lim - 1 : 0; xi = (s == 1) ? -lim : 0; end
      endcase
      valid = v; x_re = DW'(xr); x_im = DW'(xi);
      model_step(v, xr, xi);
      @(negedge clk);
    end
    compare();
    valid = 1'b0;
  endtask

  initial begin
    for (int b = 0; b < 16; b++) run(b % 4, b / 4, b % 3);
    run(3, 3, 1);
    run(1, 2, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(5 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule